// File: doc/BRIEF.md
# Regulator Power-State Sequencer

This block is the digital control state machine of a buck-boost switching regulator. It watches the enable pin, two thermal comparator flags, a feedback-undervoltage flag and the mode-control register bits. From these it steps the converter through five phases: off, input pass-through (bypass), reference settling, soft-start ramp and steady regulation. It drives the enable lines for the reference, the soft-start ramp, the converter switches, the bypass high-side switches, the output discharge resistor and the reduced-frequency short-circuit mode. It also picks between automatic PFM/PWM and forced PWM, using a pair of load-current flags that give it hysteresis.

Every timed interval counts a microsecond tick. A parameterised prescaler divides the clock to make that tick. The reference-settle time, the soft-start time and the minimum bypass dwell are each a parameter in microseconds. A simulation can therefore shorten all of them.

Top module: `pwr_seq_top`

## Requirements
- R1: After enable rises from the off state, the reference enable turns on at once. The soft-start ramp and converter start only after REF_US microsecond ticks.
- R2: Soft-start lasts SS_US ticks, with the ramp and converter enables both on. Regulation follows, with the converter on and the ramp off.
- R3: While enable is low and the bypass-disable bit is 0, the block enters bypass. Bypass turns on only the bypass switch output, and every other output stays off.
- R4: Entry into bypass and exit from bypass are each separated from the previous bypass transition by at least DWELL_US ticks, in either direction.
- R5: While enable is low and the bypass-disable bit is 1, the block stays fully off.
- R6: The discharge output is on only in the off state with enable low and the discharge bit set. It stays off when the discharge bit is clear and while in bypass.
- R7: When the over-temperature flag is seen in any powered phase, everything turns off on the next cycle. Clearing that flag alone does not restart the block. Restart happens only once the below-release flag is seen, and it then repeats the full reference-settle and soft-start sequence.
- R8: The reduced-frequency output follows the feedback-undervoltage flag while the converter is on, and is 0 otherwise.
- R9: With the force-PWM bit set and the converter on, the PWM output is 1.
- R10: In auto mode the PWM output goes to 1 one cycle after the load-high flag. It stays at 1 while neither flag is set, and goes to 0 one cycle after the load-low flag. It is 0 whenever the converter is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enable pin level |
| therm_hot_i | input | 1 | Die temperature above trip level |
| therm_cool_i | input | 1 | Die temperature below release level |
| fb_uv_i | input | 1 | Feedback below short-circuit threshold |
| load_hi_i | input | 1 | Load current above PWM entry level |
| load_lo_i | input | 1 | Load current below PFM return level |
| byp_dis_i | input | 1 | Register bit: 1 disables bypass |
| dischg_en_i | input | 1 | Register bit: 1 allows soft discharge |
| force_pwm_i | input | 1 | Register bit: 1 forces PWM |
| ref_en_o | output | 1 | Reference and bias enable |
| ss_active_o | output | 1 | Soft-start ramp running |
| conv_en_o | output | 1 | Converter switching enable |
| byp_on_o | output | 1 | Both high-side switches on (bypass) |
| dischg_o | output | 1 | Output discharge resistor on |
| lowfreq_o | output | 1 | Reduced oscillator frequency |
| pwm_o | output | 1 | 1 = PWM, 0 = PFM |

## Verification
A wrong phase counter or prescaler shows at the ports as a soft-start or regulation edge outside its tick window, within a few tens of cycles. The bench brackets each edge with one sample before the window and one sample after it. A dwell counter that is not restarted shows as a bypass edge that comes too early after the previous bypass edge. A lost thermal hysteresis state shows as a restart while only the over-temperature flag has cleared. A stuck PWM/PFM state shows one cycle after a load flag, or after a gap in which both flags are low.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF = 3'd0,
    ST_BYP = 3'd1,
    ST_REF = 3'd2,
    ST_SS  = 3'd3,
    ST_RUN = 3'd4,
    ST_HOT = 3'd5
  } seq_state_e;
endpackage

// File: rtl/pwr_tick_gen.sv
module pwr_tick_gen #(
  parameter int CLK_PER_US = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [W-1:0] LAST = W'(CLK_PER_US - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/pwr_dwell_timer.sv
module pwr_dwell_timer #(
  parameter int DWELL_US = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic restart_i,
  output logic done_o
);
  localparam int W = $clog2(DWELL_US + 1);
  localparam logic [W-1:0] FULL = W'(DWELL_US);

  logic [W-1:0] cnt_q;

  // starts saturated: no bypass edge has happened yet
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= FULL;
    else if (restart_i)             cnt_q <= '0;
    else if (tick_i && cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == FULL);

  // R4
  dwell_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !done_o);
endmodule

// File: rtl/pwr_mode_sel.sv
module pwr_mode_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic force_i,
  input  logic load_hi_i,
  input  logic load_lo_i,
  output logic pwm_o
);
  logic auto_pwm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        auto_pwm_q <= 1'b0;
    else if (!active_i) auto_pwm_q <= 1'b0;
    else if (load_hi_i) auto_pwm_q <= 1'b1;
    else if (load_lo_i) auto_pwm_q <= 1'b0;
  end

  assign pwm_o = active_i && (force_i || auto_pwm_q);

  // R10
  auto_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && load_hi_i) ##1 active_i |-> pwm_o);
  // R10
  auto_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !load_hi_i && !load_lo_i && !force_i) ##1 (active_i && !force_i) |-> $stable(pwm_o));
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top #(
  parameter int CLK_PER_US = 4,
  parameter int REF_US     = 1000,
  parameter int SS_US      = 2000,
  parameter int DWELL_US   = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic therm_hot_i,
  input  logic therm_cool_i,
  input  logic fb_uv_i,
  input  logic load_hi_i,
  input  logic load_lo_i,
  input  logic byp_dis_i,
  input  logic dischg_en_i,
  input  logic force_pwm_i,
  output logic ref_en_o,
  output logic ss_active_o,
  output logic conv_en_o,
  output logic byp_on_o,
  output logic dischg_o,
  output logic lowfreq_o,
  output logic pwm_o
);
  import pwr_seq_pkg::*;

  localparam int PH_MAX = (REF_US > SS_US) ? REF_US : SS_US;
  localparam int PW     = $clog2(PH_MAX + 1);
  localparam logic [PW-1:0] REF_LAST = PW'(REF_US - 1);
  localparam logic [PW-1:0] SS_LAST  = PW'(SS_US - 1);
  localparam int GAP_MIN = (DWELL_US - 1) * CLK_PER_US;
  localparam int GW      = $clog2(GAP_MIN + 2);

  seq_state_e st_q, st_d;
  logic [PW-1:0] ph_q;
  logic tick, dwell_ok, byp_edge, powered;

  pwr_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_o (tick)
  );

  assign byp_edge = (st_d == ST_BYP) != (st_q == ST_BYP);

  pwr_dwell_timer #(.DWELL_US(DWELL_US)) u_dwell (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tick),
    .restart_i (byp_edge), .done_o (dwell_ok)
  );

  assign powered = (st_q == ST_REF) || (st_q == ST_SS) || (st_q == ST_RUN);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF: begin
        if (en_i)                        st_d = ST_REF;
        else if (!byp_dis_i && dwell_ok) st_d = ST_BYP;
      end
      ST_BYP: begin
        if (dwell_ok) begin
          if (en_i)           st_d = ST_REF;
          else if (byp_dis_i) st_d = ST_OFF;
        end
      end
      ST_REF, ST_SS, ST_RUN: begin
        if (!en_i)            st_d = ST_OFF;
        else if (therm_hot_i) st_d = ST_HOT;
        else if (st_q == ST_REF && tick && ph_q == REF_LAST) st_d = ST_SS;
        else if (st_q == ST_SS  && tick && ph_q == SS_LAST)  st_d = ST_RUN;
      end
      ST_HOT: begin
        if (!en_i)             st_d = ST_OFF;
        else if (therm_cool_i) st_d = ST_REF;
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_OFF;
      ph_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q) ph_q <= '0;
      else if (tick)    ph_q <= ph_q + 1'b1;
    end
  end

  assign ref_en_o    = powered;
  assign ss_active_o = (st_q == ST_SS);
  assign conv_en_o   = (st_q == ST_SS) || (st_q == ST_RUN);
  assign byp_on_o    = (st_q == ST_BYP);
  assign dischg_o    = (st_q == ST_OFF) && !en_i && dischg_en_i;
  assign lowfreq_o   = conv_en_o && fb_uv_i;

  pwr_mode_sel u_mode (
    .clk_i (clk_i), .rst_ni (rst_ni), .active_i (conv_en_o),
    .force_i (force_pwm_i), .load_hi_i (load_hi_i), .load_lo_i (load_lo_i),
    .pwm_o (pwm_o)
  );

  // cycles since the last bypass edge, checked independently of the dwell timer
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         gap_q <= GW'(GAP_MIN + 1);
    else if (byp_on_o != byp_edge_seen()) gap_q <= '0;
    else if (gap_q <= GW'(GAP_MIN))      gap_q <= gap_q + 1'b1;
  end

  logic byp_prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) byp_prev_q <= 1'b0;
    else         byp_prev_q <= byp_on_o;
  end

  function automatic logic byp_edge_seen();
    return byp_prev_q;
  endfunction

  // R4
  byp_dwell_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(byp_on_o) || $fell(byp_on_o)) |-> (gap_q >= GW'(GAP_MIN)));
  // R3
  byp_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(byp_on_o) |-> $past(!en_i && !byp_dis_i));
  // R7
  hot_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_en_o && en_i && therm_hot_i) |=> !ref_en_o && !conv_en_o);
  // R1
  conv_after_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_en_o) |-> $past(ref_en_o) && ss_active_o);
  // R8
  lowfreq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lowfreq_o |-> conv_en_o && fb_uv_i);
  // R6
  dischg_byp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byp_on_o |-> !dischg_o);
endmodule

// File: tb/sim_pwr_seq_top.sv
`timescale 1ns/1ps
module sim_pwr_seq_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, hot = 0, cool = 1, uv = 0, lhi = 0, llo = 0;
  logic bdis = 1, den = 0, fpwm = 0;
  logic ref_en, ss_act, conv, byp, dis, lowf, pwm;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwr_seq_top #(.CLK_PER_US(2), .REF_US(10), .SS_US(12), .DWELL_US(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .therm_hot_i(hot), .therm_cool_i(cool),
    .fb_uv_i(uv), .load_hi_i(lhi), .load_lo_i(llo), .byp_dis_i(bdis),
    .dischg_en_i(den), .force_pwm_i(fpwm), .ref_en_o(ref_en), .ss_active_o(ss_act),
    .conv_en_o(conv), .byp_on_o(byp), .dischg_o(dis), .lowfreq_o(lowf), .pwm_o(pwm)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // R1 R2: from off, settle then ramp then regulate
  task automatic t_startup();
    en = 1;
    wait_n(15);
    check("R1", "ref_en during settle", ref_en, 1);
    check("R1", "ramp held during settle", ss_act, 0);
    check("R1", "conv held during settle", conv, 0);
    wait_n(11);
    check("R2", "ramp on", ss_act, 1);
    check("R2", "conv on in ramp", conv, 1);
    wait_n(26);
    check("R2", "ramp done", ss_act, 0);
    check("R2", "conv on in regulation", conv, 1);
  endtask

  task automatic t_mode();
    fpwm = 0;
    wait_n(1);
    check("R10", "auto starts PFM", pwm, 0);
    lhi = 1; wait_n(1); lhi = 0;
    check("R10", "load high -> PWM", pwm, 1);
    wait_n(5);
    check("R10", "hold PWM between thresholds", pwm, 1);
    llo = 1; wait_n(1); llo = 0;
    check("R10", "load low -> PFM", pwm, 0);
    fpwm = 1; wait_n(1);
    check("R9", "forced PWM", pwm, 1);
    fpwm = 0; wait_n(1);
    check("R10", "auto back to PFM", pwm, 0);
  endtask

  task automatic t_uv();
    uv = 1; wait_n(1);
    check("R8", "low freq on fault", lowf, 1);
    uv = 0; wait_n(1);
    check("R8", "low freq released", lowf, 0);
  endtask

  // R7: trip, hysteresis, full restart
  task automatic t_thermal();
    cool = 0; hot = 1;
    wait_n(1);
    check("R7", "conv off after trip", conv, 0);
    check("R7", "ref off after trip", ref_en, 0);
    hot = 0; wait_n(20);
    check("R7", "no restart above release", ref_en, 0);
    uv = 1; wait_n(1);
    check("R8", "low freq off while tripped", lowf, 0);
    uv = 0;
    cool = 1;
    wait_n(15);
    check("R7", "restart via settle: ref on", ref_en, 1);
    check("R7", "restart via settle: conv off", conv, 0);
    wait_n(11);
    check("R7", "restart ramp", ss_act, 1);
    wait_n(26);
    check("R7", "restart regulation", conv, 1);
  endtask

  task automatic t_shutdown();
    bdis = 1; den = 1; en = 0;
    wait_n(2);
    check("R5", "conv off", conv, 0);
    check("R5", "ref off", ref_en, 0);
    check("R5", "no bypass when disabled", byp, 0);
    check("R6", "discharge on", dis, 1);
    wait_n(30);
    check("R5", "still no bypass", byp, 0);
    den = 0; wait_n(1);
    check("R6", "discharge off when bit clear", dis, 0);
  endtask

  task automatic t_bypass();
    den = 1; bdis = 0;
    wait_n(2);
    check("R3", "bypass entered", byp, 1);
    check("R3", "conv off in bypass", conv, 0);
    check("R3", "ref off in bypass", ref_en, 0);
    check("R6", "no discharge in bypass", dis, 0);
    en = 1; wait_n(8);
    check("R4", "exit held by dwell", byp, 1);
    check("R4", "ref held by dwell", ref_en, 0);
    wait_n(14);
    check("R4", "exit after dwell", byp, 0);
    check("R1", "ref on after bypass exit", ref_en, 1);
    en = 0; wait_n(6);
    check("R4", "re-entry held by dwell", byp, 0);
    wait_n(16);
    check("R4", "re-entry after dwell", byp, 1);
    bdis = 1; wait_n(22);
    check("R5", "bypass left when disabled", byp, 0);
    check("R6", "discharge back on in off", dis, 1);
  endtask

  initial begin
    wait_n(3);
    check("R5", "reset ref", ref_en, 0);
    check("R5", "reset conv", conv, 0);
    check("R3", "reset bypass", byp, 0);
    check("R10", "reset pwm", pwm, 0);
    rst_n = 1;
    wait_n(2);
    t_startup();
    t_mode();
    t_uv();
    t_thermal();
    t_shutdown();
    t_bypass();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule